// File: doc/BRIEF.md
# Indexed Program Flow Checker

This block watches the stream of instruction fetch addresses from a processor and decides, for every pair of consecutive fetches, whether the jump from the earlier address (the source) to the later one (the destination) is allowed. The earlier address selects an entry in a start-pointer table. That entry and the entry after it bound a slice of a shared destination list. A small sequencer walks that slice, one entry per clock, and reports a pass as soon as an entry equals the observed destination. It reports a fail when it reaches the end of the slice. A single destination may appear in the slices of many sources, and one source may have many destinations.

Both tables are written through two plain write ports. The pointer table has one entry per possible address plus one terminal entry, which closes the slice of the highest address. Every accepted fetch becomes the source of the next pair. The first fetch after reset only seeds the source and gives no verdict.

The fetch input is a valid-only stream with no ready signal, because a processor cannot be stalled by its checker. A fetch that arrives while a search is running is not checked and raises an overrun pulse. The verdict output is also valid-only: `chk_valid` pulses for one cycle and `chk_pass` qualifies it. Nothing downstream can apply back-pressure.

Top module: `pflow_checker`

## Requirements
- R1: After reset, `busy`, `chk_valid` and `overrun` are low. Every pointer entry and every list entry is zero, so every slice is empty.
- R2: The first accepted fetch after reset loads the source register only. No verdict follows it, and `busy` stays low.
- R3: For source s and destination d, `chk_pass` is 1 with the verdict exactly when some list entry at an index i with ptr[s] <= i < ptr[s+1] equals d. Otherwise it is 0.
- R4: A fetch is accepted on a clock edge. The verdict is registered k+1 edges after that edge, where k is the offset of the first matching entry in the slice. On a miss, k is the slice length.
- R5: `busy` is high in every cycle from the accept edge up to the verdict edge, and it is low in the cycle where `chk_valid` is high.
- R6: A fetch presented while `busy` is high raises `overrun` for one cycle after that edge. It is not checked and does not replace the source register.
- R7: The destination of each checked pair becomes the source of the next pair.
- R8: When ptr[s] >= ptr[s+1], the slice is empty and a fail verdict comes one edge after the accept edge.
- R9: A write with `ptr_we` stores `ptr_val` at index `ptr_idx`, where index 2^AW is the terminal entry. A write with `dst_we` stores `dst_val` at `dst_idx`. Both writes affect all later searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch address is present this cycle |
| fetch_addr | input | AW | Fetch address |
| ptr_we | input | 1 | Pointer table write strobe |
| ptr_idx | input | AW+1 | Pointer table index, 0 to 2^AW |
| ptr_val | input | PW | Start position to store, PW = clog2(NDST+1) |
| dst_we | input | 1 | Destination list write strobe |
| dst_idx | input | IW | List index, IW = clog2(NDST) |
| dst_val | input | AW | Destination address to store |
| busy | output | 1 | A search is in progress |
| chk_valid | output | 1 | One-cycle verdict strobe |
| chk_pass | output | 1 | Verdict: 1 means the pair is allowed |
| overrun | output | 1 | One-cycle pulse: a fetch came in during a search |

## Verification
The hardest situation to reach from the ports is a fetch that lands in the middle of a multi-cycle search, followed by proof that it neither disturbed the verdict in flight nor replaced the source. The bench sets up a source with a three-entry slice and presents a missing destination so that the search runs its full length. It injects a second fetch one cycle in. It then presents an address that is valid only from the retained source and invalid from the dropped one. The terminal pointer entry is reached in the same spirit: the slice of the highest address is extended by rewriting that entry, and a hit on its second element is checked.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [0:0] {PF_IDLE, PF_SCAN} pf_state_e;
endpackage

// File: rtl/pfc_ptr_table.sv
module pfc_ptr_table #(
  parameter int AW = 8,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   wr_idx,
  input  logic [PW-1:0] wr_val,
  input  logic [AW-1:0] rd_idx,
  output logic [PW-1:0] rd_lo,
  output logic [PW-1:0] rd_hi
);
  localparam int N = (1 << AW) + 1;

  logic [PW-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && wr_idx == (AW+1)'(i))
        mem[i] <= wr_val;
    end
  end

  logic [AW:0] lo_i, hi_i;
  assign lo_i  = {1'b0, rd_idx};
  assign hi_i  = lo_i + (AW+1)'(1);
  assign rd_lo = mem[lo_i];
  assign rd_hi = mem[hi_i];
endmodule

// File: rtl/pfc_dst_list.sv
module pfc_dst_list #(
  parameter int AW   = 8,
  parameter int NDST = 64,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_val,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_val
);
  logic [AW-1:0] mem [NDST];

  for (genvar i = 0; i < NDST; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && wr_idx == IW'(i))
        mem[i] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NDST = 64,
  parameter int PW   = 7,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic [PW-1:0] slice_lo,
  input  logic [PW-1:0] slice_hi,
  input  logic [AW-1:0] entry,
  output logic [AW-1:0] src,
  output logic [IW-1:0] cur_idx,
  output logic          busy,
  output logic          chk_valid,
  output logic          chk_pass,
  output logic          overrun
);
  pf_state_e     state;
  logic          have_src;
  logic [PW-1:0] cur, lim;
  logic [AW-1:0] dst;
  logic          at_end;

  assign at_end  = (cur >= lim) || (cur >= PW'(NDST));
  assign cur_idx = cur[IW-1:0];
  assign busy    = (state == PF_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PF_IDLE;
      have_src  <= 1'b0;
      src       <= '0;
      dst       <= '0;
      cur       <= '0;
      lim       <= '0;
      chk_valid <= 1'b0;
      chk_pass  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      chk_valid <= 1'b0;
      overrun   <= fetch_valid && (state == PF_SCAN);
      case (state)
        PF_IDLE: begin
          if (fetch_valid) begin
            src      <= fetch_addr;
            have_src <= 1'b1;
            if (have_src) begin
              cur   <= slice_lo;
              lim   <= slice_hi;
              dst   <= fetch_addr;
              state <= PF_SCAN;
            end
          end
        end
        PF_SCAN: begin
          if (at_end) begin
            chk_valid <= 1'b1;
            chk_pass  <= 1'b0;
            state     <= PF_IDLE;
          end else if (entry == dst) begin
            chk_valid <= 1'b1;
            chk_pass  <= 1'b1;
            state     <= PF_IDLE;
          end else begin
            cur <= cur + PW'(1);
          end
        end
        default: state <= PF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pflow_checker.sv
module pflow_checker #(
  parameter int AW   = 8,
  parameter int NDST = 64,
  localparam int PW  = $clog2(NDST + 1),
  localparam int IW  = $clog2(NDST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ptr_we,
  input  logic [AW:0]   ptr_idx,
  input  logic [PW-1:0] ptr_val,
  input  logic          dst_we,
  input  logic [IW-1:0] dst_idx,
  input  logic [AW-1:0] dst_val,
  output logic          busy,
  output logic          chk_valid,
  output logic          chk_pass,
  output logic          overrun
);
  logic [AW-1:0] src;
  logic [PW-1:0] slice_lo, slice_hi;
  logic [IW-1:0] cur_idx;
  logic [AW-1:0] entry;

  pfc_ptr_table #(.AW(AW), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ptr_we), .wr_idx(ptr_idx), .wr_val(ptr_val),
    .rd_idx(src), .rd_lo(slice_lo), .rd_hi(slice_hi)
  );

  pfc_dst_list #(.AW(AW), .NDST(NDST), .IW(IW)) u_dst (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dst_we), .wr_idx(dst_idx), .wr_val(dst_val),
    .rd_idx(cur_idx), .rd_val(entry)
  );

  pfc_seq #(.AW(AW), .NDST(NDST), .PW(PW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .slice_lo(slice_lo), .slice_hi(slice_hi), .entry(entry),
    .src(src), .cur_idx(cur_idx), .busy(busy),
    .chk_valid(chk_valid), .chk_pass(chk_pass), .overrun(overrun)
  );
endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
  parameter int NDST = 64
) (
  input logic clk,
  input logic rst_n,
  input logic fetch_valid,
  input logic busy,
  input logic chk_valid,
  input logic overrun
);
  localparam int CW = $clog2(NDST + 3) + 1;
  logic [CW-1:0] span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span <= '0;
    else if (busy) span <= span + CW'(1);
    else           span <= '0;
  end

  // R5
  verdict_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(busy));

  // R5
  verdict_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !busy);

  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fetch_valid && busy));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fetch_valid));

  // R4
  search_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span <= CW'(NDST + 1));
endmodule

bind pflow_checker pfc_chk #(.NDST(NDST)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
  .busy(busy), .chk_valid(chk_valid), .overrun(overrun)
);

// File: tb/sim_pflow_checker.sv
module sim_pflow_checker;
  localparam int AW   = 8;
  localparam int NDST = 64;
  localparam int PW   = $clog2(NDST + 1);
  localparam int IW   = $clog2(NDST);
  localparam int NPTR = (1 << AW) + 1;

  logic clk, rst_n;
  logic fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic ptr_we, dst_we;
  logic [AW:0] ptr_idx;
  logic [PW-1:0] ptr_val;
  logic [IW-1:0] dst_idx;
  logic [AW-1:0] dst_val;
  logic busy, chk_valid, chk_pass, overrun;

  int checks = 0, fails = 0;
  int exp_ptr [NPTR];
  int exp_dst [NDST];
  bit have_prev = 0;
  int prev = 0;
  bit finished = 0;

  pflow_checker #(.AW(AW), .NDST(NDST)) u0 (.*);

  initial begin clk = 0; forever #2 clk = ~clk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int s);
    return (s < 16) ? (s % 4) : 0;
  endfunction

  function automatic int dst_of(input int s, input int j);
    return (s * 7 + j * 13 + 1) & 255;
  endfunction

  task automatic wr_ptr(input int i, input int v);
    @(negedge clk); ptr_we = 1; ptr_idx = (AW+1)'(i); ptr_val = PW'(v);
    @(negedge clk); ptr_we = 0;
    exp_ptr[i] = v;
  endtask

  task automatic wr_dst(input int i, input int v);
    @(negedge clk); dst_we = 1; dst_idx = IW'(i); dst_val = AW'(v);
    @(negedge clk); dst_we = 0;
    exp_dst[i] = v;
  endtask

  // Bench model: returns match offset (or -1) and the negedge count of the verdict.
  task automatic model(input int s, input int d, output int pos, output int lat);
    int lo, hi, len;
    lo = exp_ptr[s]; hi = exp_ptr[s + 1];
    pos = -1;
    for (int i = lo; i < hi && i < NDST; i++)
      if (pos < 0 && exp_dst[i] == d) pos = i - lo;
    len = (hi > lo) ? ((hi < NDST ? hi : NDST) - lo) : 0;
    lat = (pos >= 0) ? pos + 2 : len + 2;
  endtask

  task automatic do_fetch(input int a);
    int n, pos, lat;
    @(negedge clk); fetch_valid = 1; fetch_addr = AW'(a);
    @(negedge clk); fetch_valid = 0; n = 1;
    if (!have_prev) begin
      // R2: first fetch seeds the source only
      chk(busy == 0, "R2 busy", busy, 0);
      for (int k = 0; k < 6; k++) begin
        if (chk_valid) n = 99;
        @(negedge clk);
      end
      chk(n != 99, "R2 no verdict", chk_valid, 0);
    end else begin
      model(prev, a, pos, lat);
      while (!chk_valid && n < 200) begin
        chk(busy == 1, "R5 busy during search", busy, 1);
        @(negedge clk); n++;
      end
      chk(n == lat, "R4 latency", n, lat);
      chk(chk_pass == (pos >= 0), "R3 R7 verdict", chk_pass, pos >= 0);
      chk(busy == 0, "R5 busy low at verdict", busy, 0);
      if (exp_ptr[prev] >= exp_ptr[prev + 1])
        chk(n == 2 && !chk_pass, "R8 empty slice", n, 2);
    end
    prev = a; have_prev = 1;
  endtask

  initial begin
    int st, n, pos, lat;
    rst_n = 0; fetch_valid = 0; fetch_addr = 0;
    ptr_we = 0; ptr_idx = 0; ptr_val = 0; dst_we = 0; dst_idx = 0; dst_val = 0;
    for (int i = 0; i < NPTR; i++) exp_ptr[i] = 0;
    for (int i = 0; i < NDST; i++) exp_dst[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(busy == 0 && chk_valid == 0 && overrun == 0, "R1 reset outputs",
        {busy, chk_valid, overrun}, 0);
    // R1: empty tables give a fail after reset
    do_fetch(9);
    do_fetch(10);

    // R9: load tables
    st = 0;
    for (int s = 0; s < NPTR; s++) begin
      wr_ptr(s, st);
      for (int j = 0; j < cnt_of(s); j++) wr_dst(st + j, dst_of(s, j));
      st += cnt_of(s);
    end

    // R3 R7 R8: sweep every source 0..19 with each listed and one unlisted destination
    for (int s = 0; s < 20; s++) begin
      for (int j = 0; j <= cnt_of(s); j++) begin
        do_fetch(s);
        do_fetch(j < cnt_of(s) ? dst_of(s, j) : (dst_of(s, 0) ^ 8'h55));
      end
    end

    // R6: fetch during a full-length miss search
    do_fetch(3);
    @(negedge clk); fetch_valid = 1; fetch_addr = 8'd2;
    @(negedge clk); fetch_addr = 8'd5; n = 1;
    @(negedge clk); fetch_valid = 0; n = 2;
    chk(overrun == 1, "R6 overrun pulse", overrun, 1);
    while (!chk_valid && n < 200) begin @(negedge clk); n++; end
    chk(n == 5 && chk_pass == 0, "R6 verdict undisturbed", n, 5);
    @(negedge clk);
    chk(overrun == 0, "R6 overrun one cycle", overrun, 0);
    prev = 2;
    // R6: source still 2, so 15 is allowed (not from 5)
    do_fetch(15);

    // R9: terminal entry extends the slice of the highest address
    wr_dst(24, 8'h10);
    wr_dst(25, 8'h20);
    wr_ptr(NPTR - 1, 26);
    do_fetch(255);
    model(255, 8'h20, pos, lat);
    chk(pos == 1, "R9 model terminal", pos, 1);
    do_fetch(8'h20);
    // R9: rewrite one list entry and see it take effect
    wr_dst(0, 8'hAB);
    do_fetch(1);
    do_fetch(8'hAB);
    do_fetch(1);
    do_fetch(dst_of(1, 0));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule